// File: doc/BRIEF.md
# Debug-Board Interrupt Aggregator and Register Bank

This block is the logic device that sits between a host memory bus and the peripherals on a plug-in debug board. It collects interrupt requests from an Ethernet controller, two external UARTs and two push buttons, plus eleven spare lines. Each request is latched into a sticky 16-bit status word. A set-to-disable mask selects which latched lines may reach the host. The block drives one active-low, level-sensitive interrupt pin to the host. Software acknowledges a line by writing a 1 to its bit in a clear register and then writing 0 back.

The same 16-bit register space also holds several other registers. Three constant signature words let software confirm the board is fitted. There is a build-time firmware version and a board identifier captured from strap pins. An LED register drives the board LEDs and a switch register reads back the board switches. A module-reset register drives one reset output per peripheral. Registers are selected by byte offset. A read of an unmapped offset returns zero, and writes to read-only offsets change nothing.

Top module: `dbg_cpld_bridge`

## Requirements
- R1: After reset the mask reads 0xFFFF, the status reads 0, `host_irq_n_o` is 1, and the LED and module-reset outputs are 0.
- R2: Offset 0x40 reads 0xAAAA, 0x48 reads 0x5555 and 0x58 reads 0xCAFE. Writes to these offsets do not alter them.
- R3: Offset 0x50 returns the `CODE_VER` parameter. Offset 0x68 returns the value of `strap_i` taken on the first clock after reset, and later strap changes do not alter it.
- R4: The mask at 0x38 is read/write, and a 1 disables a line. `host_irq_n_o` is 0 exactly when some status bit is 1 and its mask bit is 0. The output lags the state by one register stage.
- R5: The status at offset 0x10 holds bit i for request line i. Bit 0 is Ethernet, bit 1 is UART A, bit 2 is UART B, bit 3 is button A and bit 4 is button B. Line 0 is active low and all other lines are active high. Level lines (all except 3 and 4) set their bit on every cycle the synchronized request is active. The bit stays set after the request goes away.
- R6: Lines 3 and 4 set their status bit only on the rising edge of the synchronized request. Once cleared, the bit stays 0 while the request is held.
- R7: The clear register at 0x20 is read/write. Each bit that holds 1 clears the matching status bit on the next clock. When a set and a clear occur in the same cycle, the set wins.
- R8: The LED register at 0x00 and the module-reset register at 0x60 are read/write and drive `led_o` and `mod_rst_o` directly.
- R9: Offset 0x08 returns `sw_i` after a two-flop synchronizer.
- R10: Reads of unmapped offsets return 0. Writes to status, switch, signature, version and board-ID offsets, and to unmapped offsets, change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_cs_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Byte offset of the register |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data, valid in the strobe cycle, 0 when idle |
| irq_req_i | input | 16 | Raw peripheral interrupt requests |
| sw_i | input | SW_W | Board switch inputs |
| strap_i | input | 16 | Board identifier strap pins |
| led_o | output | LED_W | LED drive |
| mod_rst_o | output | 16 | Per-peripheral reset outputs |
| host_irq_n_o | output | 1 | Active-low level interrupt to the host |

## Verification
Each of the sixteen request lines is pulsed on its own. The bench then checks that exactly that status bit appears, so a swapped, merged or wrongly inverted line shows up. Three mask patterns are applied per line: enable only that line, disable only that line, and enable everything. These show whether the mask polarity and the output gating are correct. A request held across an acknowledge separates level lines, which re-set, from edge lines, which stay clear. A clear bit held high while a line pulses shows that a set wins over a simultaneous clear. A combined three-line pattern checks that the status bits OR together and that the mask gates each bit separately.

// File: rtl/brdbr_pkg.sv
package brdbr_pkg;

  localparam int REG_W  = 16;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_LED  = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_SW   = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_STAT = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_CLR  = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_MASK = 8'h38;
  localparam logic [ADDR_W-1:0] OFS_SIG0 = 8'h40;
  localparam logic [ADDR_W-1:0] OFS_SIG1 = 8'h48;
  localparam logic [ADDR_W-1:0] OFS_VER  = 8'h50;
  localparam logic [ADDR_W-1:0] OFS_SIG2 = 8'h58;
  localparam logic [ADDR_W-1:0] OFS_MRST = 8'h60;
  localparam logic [ADDR_W-1:0] OFS_BID  = 8'h68;

  localparam logic [REG_W-1:0] SIG0_VAL = 16'hAAAA;
  localparam logic [REG_W-1:0] SIG1_VAL = 16'h5555;
  localparam logic [REG_W-1:0] SIG2_VAL = 16'hCAFE;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_LED,
    SEL_SW,
    SEL_STAT,
    SEL_CLR,
    SEL_MASK,
    SEL_SIG0,
    SEL_SIG1,
    SEL_VER,
    SEL_SIG2,
    SEL_MRST,
    SEL_BID
  } reg_sel_e;

  function automatic reg_sel_e decode_ofs(input logic [ADDR_W-1:0] a);
    reg_sel_e s;
    case (a)
      OFS_LED:  s = SEL_LED;
      OFS_SW:   s = SEL_SW;
      OFS_STAT: s = SEL_STAT;
      OFS_CLR:  s = SEL_CLR;
      OFS_MASK: s = SEL_MASK;
      OFS_SIG0: s = SEL_SIG0;
      OFS_SIG1: s = SEL_SIG1;
      OFS_VER:  s = SEL_VER;
      OFS_SIG2: s = SEL_SIG2;
      OFS_MRST: s = SEL_MRST;
      OFS_BID:  s = SEL_BID;
      default:  s = SEL_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/brdbr_sync.sv
module brdbr_sync #(
  parameter int           W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;

endmodule

// File: rtl/brdbr_irq_core.sv
module brdbr_irq_core #(
  parameter int           N          = 16,
  parameter logic [N-1:0] EDGE_LINES = '0,
  parameter logic [N-1:0] LOW_LINES  = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] mask_i,
  output logic [N-1:0] status_o,
  output logic         irq_n_o
);

  logic [N-1:0] req_sync;
  logic [N-1:0] lvl;
  logic [N-1:0] prev_q;
  logic [N-1:0] set_vec;
  logic [N-1:0] status_q;
  logic [N-1:0] status_d;
  logic [N-1:0] pend;
  logic         irq_n_q;
  logic         irq_n_d;

  // Idle value of active-low lines is 1, so reset the synchronizer there.
  brdbr_sync #(
    .W       (N),
    .RST_VAL (LOW_LINES)
  ) u_req_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (req_i),
    .q_o   (req_sync)
  );

  assign lvl = req_sync ^ LOW_LINES;

  for (genvar gi = 0; gi < N; gi++) begin : g_line
    if (EDGE_LINES[gi]) begin : g_edge
      assign set_vec[gi] = lvl[gi] & ~prev_q[gi];

      AST_EDGE_RISE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_q[gi]) |-> $past(lvl[gi] & ~prev_q[gi])); // R6
    end else begin : g_level
      assign set_vec[gi] = lvl[gi];
    end
  end

  always_comb begin
    status_d = (status_q & ~clr_i) | set_vec;
    pend     = status_q & ~mask_i;
    irq_n_d  = ~|pend;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      status_q <= '0;
      irq_n_q  <= 1'b1;
    end else begin
      prev_q   <= lvl;
      status_q <= status_d;
      irq_n_q  <= irq_n_d;
    end
  end

  assign status_o = status_q;
  assign irq_n_o  = irq_n_q;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((status_q & $past(set_vec)) == $past(set_vec))); // R7

  AST_FALL_NEEDS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(status_q) & ~status_q) & ~$past(clr_i)) == '0)); // R7

  AST_ALL_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_i) |=> irq_n_o); // R4

endmodule

// File: rtl/brdbr_regs.sv
module brdbr_regs
  import brdbr_pkg::*;
#(
  parameter int               SW_W     = 8,
  parameter int               LED_W    = 8,
  parameter logic [REG_W-1:0] CODE_VER = 16'h0100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic [REG_W-1:0]  status_i,
  input  logic [SW_W-1:0]   sw_i,
  input  logic [REG_W-1:0]  strap_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic [REG_W-1:0]  mask_o,
  output logic [REG_W-1:0]  clr_o,
  output logic [LED_W-1:0]  led_o,
  output logic [REG_W-1:0]  mod_rst_o
);

  reg_sel_e         sel;
  logic             wr;
  logic             led_en;
  logic             mask_en;
  logic             clr_en;
  logic             mrst_en;
  logic             bid_en;
  logic [LED_W-1:0] led_q;
  logic [REG_W-1:0] mask_q;
  logic [REG_W-1:0] clr_q;
  logic [REG_W-1:0] mrst_q;
  logic [REG_W-1:0] bid_q;
  logic             bid_done_q;
  logic [REG_W-1:0] rd_led;
  logic [REG_W-1:0] rd_sw;
  logic [REG_W-1:0] rd_val;

  assign sel = decode_ofs(addr_i);
  assign wr  = cs_i & we_i;

  always_comb begin
    led_en  = wr && (sel == SEL_LED);
    mask_en = wr && (sel == SEL_MASK);
    clr_en  = wr && (sel == SEL_CLR);
    mrst_en = wr && (sel == SEL_MRST);
    bid_en  = !bid_done_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      led_q      <= '0;
      mask_q     <= '1;
      clr_q      <= '0;
      mrst_q     <= '0;
      bid_q      <= '0;
      bid_done_q <= 1'b0;
    end else begin
      if (led_en)  led_q  <= wdata_i[LED_W-1:0];
      if (mask_en) mask_q <= wdata_i;
      if (clr_en)  clr_q  <= wdata_i;
      if (mrst_en) mrst_q <= wdata_i;
      if (bid_en) begin
        bid_q      <= strap_i;
        bid_done_q <= 1'b1;
      end
    end
  end

  always_comb begin
    rd_led = '0;
    rd_led[LED_W-1:0] = led_q;
    rd_sw = '0;
    rd_sw[SW_W-1:0] = sw_i;
    case (sel)
      SEL_LED:  rd_val = rd_led;
      SEL_SW:   rd_val = rd_sw;
      SEL_STAT: rd_val = status_i;
      SEL_CLR:  rd_val = clr_q;
      SEL_MASK: rd_val = mask_q;
      SEL_SIG0: rd_val = SIG0_VAL;
      SEL_SIG1: rd_val = SIG1_VAL;
      SEL_VER:  rd_val = CODE_VER;
      SEL_SIG2: rd_val = SIG2_VAL;
      SEL_MRST: rd_val = mrst_q;
      SEL_BID:  rd_val = bid_q;
      default:  rd_val = '0;
    endcase
    rdata_o = cs_i ? rd_val : '0;
  end

  assign mask_o    = mask_q;
  assign clr_o     = clr_q;
  assign led_o     = led_q;
  assign mod_rst_o = mrst_q;

  AST_MASK_TAKES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_i && we_i && addr_i == OFS_MASK) |=> (mask_o == $past(wdata_i))); // R4

  AST_MRST_TAKES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_i && we_i && addr_i == OFS_MRST) |=> (mod_rst_o == $past(wdata_i))); // R8

  AST_BID_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    bid_done_q |=> $stable(bid_q)); // R3

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_i && !we_i && sel == SEL_NONE) |-> (rdata_o == '0)); // R10

endmodule

// File: rtl/dbg_cpld_bridge.sv
module dbg_cpld_bridge
  import brdbr_pkg::*;
#(
  parameter int               SW_W       = 8,
  parameter int               LED_W      = 8,
  parameter logic [REG_W-1:0] CODE_VER   = 16'h0100,
  parameter logic [REG_W-1:0] EDGE_LINES = 16'h0018,
  parameter logic [REG_W-1:0] LOW_LINES  = 16'h0001
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              bus_cs_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [REG_W-1:0]  bus_wdata_i,
  output logic [REG_W-1:0]  bus_rdata_o,
  input  logic [REG_W-1:0]  irq_req_i,
  input  logic [SW_W-1:0]   sw_i,
  input  logic [REG_W-1:0]  strap_i,
  output logic [LED_W-1:0]  led_o,
  output logic [REG_W-1:0]  mod_rst_o,
  output logic              host_irq_n_o
);

  logic             rst_meta_q;
  logic             rst_n;
  logic [SW_W-1:0]  sw_sync;
  logic [REG_W-1:0] status;
  logic [REG_W-1:0] mask;
  logic [REG_W-1:0] clr;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      rst_meta_q <= 1'b0;
      rst_n      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n      <= rst_meta_q;
    end
  end

  brdbr_sync #(
    .W       (SW_W),
    .RST_VAL ('0)
  ) u_sw_sync (
    .clk   (clk_i),
    .rst_n (rst_n),
    .d_i   (sw_i),
    .q_o   (sw_sync)
  );

  brdbr_irq_core #(
    .N          (REG_W),
    .EDGE_LINES (EDGE_LINES),
    .LOW_LINES  (LOW_LINES)
  ) u_irq (
    .clk      (clk_i),
    .rst_n    (rst_n),
    .req_i    (irq_req_i),
    .clr_i    (clr),
    .mask_i   (mask),
    .status_o (status),
    .irq_n_o  (host_irq_n_o)
  );

  brdbr_regs #(
    .SW_W     (SW_W),
    .LED_W    (LED_W),
    .CODE_VER (CODE_VER)
  ) u_regs (
    .clk       (clk_i),
    .rst_n     (rst_n),
    .cs_i      (bus_cs_i),
    .we_i      (bus_we_i),
    .addr_i    (bus_addr_i),
    .wdata_i   (bus_wdata_i),
    .status_i  (status),
    .sw_i      (sw_sync),
    .strap_i   (strap_i),
    .rdata_o   (bus_rdata_o),
    .mask_o    (mask),
    .clr_o     (clr),
    .led_o     (led_o),
    .mod_rst_o (mod_rst_o)
  );

endmodule

// File: tb/dbg_cpld_bridge_tb.sv
`timescale 1ns/1ps
module dbg_cpld_bridge_tb;

  localparam logic [15:0] VER   = 16'h1A2B;
  localparam logic [15:0] IDLE  = 16'h0001;
  localparam logic [15:0] STRAP = 16'h3C3C;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cs, we;
  logic [7:0]  addr;
  logic [15:0] wdata, rdata;
  logic [15:0] req;
  logic [7:0]  sw;
  logic [15:0] strap;
  logic [7:0]  led;
  logic [15:0] mrst;
  logic        irq_n;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  dbg_cpld_bridge #(
    .SW_W     (8),
    .LED_W    (8),
    .CODE_VER (VER)
  ) u_dut (
    .clk_i        (clk),
    .rst_n_i      (rst_n),
    .bus_cs_i     (cs),
    .bus_we_i     (we),
    .bus_addr_i   (addr),
    .bus_wdata_i  (wdata),
    .bus_rdata_o  (rdata),
    .irq_req_i    (req),
    .sw_i         (sw),
    .strap_i      (strap),
    .led_o        (led),
    .mod_rst_o    (mrst),
    .host_irq_n_o (irq_n)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    cs = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    cs = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk);
    cs = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    cs = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ack(input logic [15:0] bits);
    wr(8'h20, bits);
    wr(8'h20, 16'h0000);
    idle(2);
  endtask

  logic [15:0] v;

  initial begin
    rst_n = 1'b0; cs = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    req = IDLE; sw = 8'h5A; strap = STRAP;
    idle(5);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    rd(8'h38, v); chk("R1 mask", v, 16'hFFFF);
    rd(8'h10, v); chk("R1 status", v, 16'h0000);
    chk("R1 irq_n", {15'd0, irq_n}, 16'h0001);
    chk("R1 led", {8'd0, led}, 16'h0000);
    chk("R1 modrst", mrst, 16'h0000);

    // R2 signature words, read-only
    rd(8'h40, v); chk("R2 sig0", v, 16'hAAAA);
    rd(8'h48, v); chk("R2 sig1", v, 16'h5555);
    rd(8'h58, v); chk("R2 sig2", v, 16'hCAFE);
    wr(8'h40, 16'h0000); wr(8'h58, 16'h1234);
    rd(8'h40, v); chk("R2 sig0 after write", v, 16'hAAAA);
    rd(8'h58, v); chk("R2 sig2 after write", v, 16'hCAFE);

    // R3 version and strap capture
    rd(8'h50, v); chk("R3 version", v, VER);
    strap = 16'h0000; idle(3);
    rd(8'h68, v); chk("R3 board id", v, STRAP);
    wr(8'h68, 16'hFFFF);
    rd(8'h68, v); chk("R10 board id write ignored", v, STRAP);

    // R9 switches
    rd(8'h08, v); chk("R9 switches", v, 16'h005A);
    sw = 8'hA5; idle(3);
    rd(8'h08, v); chk("R9 switches new", v, 16'h00A5);

    // R8 LED and module reset
    wr(8'h00, 16'hFF81); idle(1);
    chk("R8 led out", {8'd0, led}, 16'h0081);
    rd(8'h00, v); chk("R8 led read", v, 16'h0081);
    wr(8'h60, 16'h0013); idle(1);
    chk("R8 modrst out", mrst, 16'h0013);
    rd(8'h60, v); chk("R8 modrst read", v, 16'h0013);

    // R10 unmapped and read-only offsets
    rd(8'h18, v); chk("R10 unmapped 18", v, 16'h0000);
    rd(8'h70, v); chk("R10 unmapped 70", v, 16'h0000);
    rd(8'hFF, v); chk("R10 unmapped FF", v, 16'h0000);
    wr(8'h18, 16'h0000); wr(8'h10, 16'hFFFF); wr(8'h08, 16'h0000);
    rd(8'h38, v); chk("R10 mask untouched", v, 16'hFFFF);
    rd(8'h10, v); chk("R10 status untouched", v, 16'h0000);
    rd(8'h08, v); chk("R10 switches untouched", v, 16'h00A5);

    // R4/R5/R6 per-line sweep
    wr(8'h38, 16'h0000);
    for (int i = 0; i < 16; i++) begin
      logic [15:0] b;
      b = 16'h0001 << i;
      req = IDLE ^ b; idle(6);
      req = IDLE; idle(6);
      rd(8'h10, v); chk($sformatf("R5 status line %0d", i), v, b);
      wr(8'h38, ~b); idle(2);
      chk($sformatf("R4 enabled line %0d", i), {15'd0, irq_n}, 16'h0000);
      wr(8'h38, b); idle(2);
      chk($sformatf("R4 disabled line %0d", i), {15'd0, irq_n}, 16'h0001);
      wr(8'h38, 16'h0000); idle(2);
      chk($sformatf("R4 all enabled line %0d", i), {15'd0, irq_n}, 16'h0000);
      ack(b);
      rd(8'h10, v); chk($sformatf("R7 cleared line %0d", i), v, 16'h0000);
      chk($sformatf("R4 idle line %0d", i), {15'd0, irq_n}, 16'h0001);
    end

    // R5 level line held across clear re-sets; R6 edge line held stays clear
    req = IDLE ^ 16'h000A; idle(6);
    rd(8'h10, v); chk("R5/R6 held set", v, 16'h000A);
    ack(16'h000A); idle(4);
    rd(8'h10, v); chk("R5 level re-set, R6 edge stays clear", v, 16'h0002);
    req = IDLE; idle(6);
    rd(8'h10, v); chk("R5 sticky after release", v, 16'h0002);
    ack(16'hFFFF);
    rd(8'h10, v); chk("R7 clear all", v, 16'h0000);

    // R7 held clear bit against a pulse: set wins while active
    wr(8'h20, 16'h0004);
    req = IDLE ^ 16'h0004; idle(6);
    rd(8'h10, v); chk("R7 set wins", v, 16'h0004);
    req = IDLE; idle(6);
    rd(8'h10, v); chk("R7 held clear erases", v, 16'h0000);
    rd(8'h20, v); chk("R7 clear readback", v, 16'h0004);
    wr(8'h20, 16'h0000);

    // R4/R5 combined pattern
    req = IDLE ^ 16'h0015; idle(6);
    req = IDLE; idle(6);
    rd(8'h10, v); chk("R5 combined status", v, 16'h0015);
    wr(8'h38, 16'h0015); idle(2);
    chk("R4 combined masked", {15'd0, irq_n}, 16'h0001);
    wr(8'h38, 16'h0014); idle(2);
    chk("R4 combined one open", {15'd0, irq_n}, 16'h0000);
    ack(16'h0015);
    chk("R4 combined after clear", {15'd0, irq_n}, 16'h0001);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule